// File: doc/BRIEF.md
# Boot-Progress-Armed Watchdog

This block is a watchdog that a host enables early but that does not start counting on enable alone. It watches I/O write cycles on a snoop port. Writes to the boot-progress port are captured into a data register and into a read-only copy of the most recent byte. The countdown starts only when a captured byte equals a programmed start code. Once started, the counter counts down a programmed number of time units. The unit is one of four tick rates, made by dividing a base tick input.

When the count runs out, the block sets a sticky timeout flag and drives a per-pin masked event bus until the next tick of the selected rate. It then waits for the next start code. The host reaches its five byte registers through a simple write strobe, a 3-bit offset and a combinational read bus. A synchronous active-high reset returns every register to its default.

The controller has four states. IDLE means the watchdog is disabled. WAIT_CODE means it is enabled and waiting for the code. COUNT means the countdown is running. FIRE means the event outputs are driven. The transitions are:
- `arm`: IDLE to WAIT_CODE, when the enable bit is set.
- `start`: WAIT_CODE to COUNT, on a code match. The counter loads the count-time value and the prescaler restarts.
- `step`: COUNT to COUNT, on a selected tick while the count is above 1. The count decrements.
- `expire`: COUNT to FIRE, on a selected tick while the count is 0 or 1.
- `rearm`: FIRE to WAIT_CODE, on the next selected tick.
- `abort`: from any state to IDLE, whenever the enable bit is clear.

Top module: `post_wdt`

## Requirements
- R1: After reset, the registers read as follows: control (offset 0) 0x00, count time (offset 1) 0xFF, start code (offset 2) 0x00, captured data (offset 3) 0x00, last byte (offset 4) 0x00. The event bus is 0.
- R2: While enabled and waiting, snooped writes whose data differs from the start code never start a countdown, and no event occurs however many ticks arrive.
- R3: Every snooped write to port 0x80 is captured into offsets 3 and 4. A write to port 0x81 is captured, and can start the watchdog, only while `pair_decode` is high.
- R4: A code match while waiting loads the count-time value N. With N > 0, the expiry comes on the N-th selected tick after the match and sets control bit 7.
- R5: At expiry, `evt_out` equals control bits 3:0. It stays at that value until the next selected tick, then returns to 0, and the block waits for the code again.
- R6: Writing control with bit 7 = 1 clears the timeout flag. Writing it with bit 7 = 0 leaves the flag unchanged. Bits 6:0 always take the written value.
- R7: Clearing control bit 6 (enable) during a countdown aborts it. No event follows and the flag stays clear.
- R8: A count time of 0 expires on the first selected tick after the match.
- R9: Control bits 5:4 (unit u) select one counting tick per DIV^u base ticks (DIV = 4), counted from the match.
- R10: When a flag-clear write and an expiry fall in the same cycle, the flag ends up set.
- R11: Offset 4 is read-only. A host write to offset 3 or offset 4 leaves offset 4 unchanged.
- R12: A code match that arrives while a countdown is running neither reloads nor restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| io_wr | input | 1 | Snooped I/O write strobe |
| io_addr | input | 16 | Snooped I/O write address |
| io_data | input | 8 | Snooped I/O write data |
| pair_decode | input | 1 | Also decode port 0x81 |
| base_tick | input | 1 | One-cycle base time tick |
| evt_out | output | 4 | Masked timeout event bus |

## Verification
Two collisions matter here. The first is a timeout expiry meeting a host write that clears the flag in the same clock. The bench provokes it by pulsing `base_tick` in the very cycle that a control write with bit 7 = 1 is presented to a watchdog armed with a count of 1. It then judges the result by reading bit 7 back as 1. The second is a start-code match landing during a countdown. The scoreboard judges that case by requiring the event after the original tick count, not a reloaded one.

// File: rtl/post_wdt_pkg.sv
package post_wdt_pkg;

    localparam int DW     = 8;
    localparam int EVT_W  = 4;
    localparam int RA_W   = 3;

    localparam logic [RA_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [RA_W-1:0] OFS_TIME = 3'd1;
    localparam logic [RA_W-1:0] OFS_CODE = 3'd2;
    localparam logic [RA_W-1:0] OFS_DATA = 3'd3;
    localparam logic [RA_W-1:0] OFS_LAST = 3'd4;

    localparam logic [DW-1:0] TIME_RST = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_CODE,
        ST_COUNT,
        ST_FIRE
    } wdt_state_e;

    typedef struct packed {
        logic             stat;
        logic             en;
        logic [1:0]       unit;
        logic [EVT_W-1:0] mask;
    } wdt_ctrl_t;

endpackage

// File: rtl/post_wdt_regs.sv
module post_wdt_regs
    import post_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [RA_W-1:0]  addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             cap,
    input  logic [DW-1:0]    cap_data,
    input  logic             expire,
    output wdt_ctrl_t        ctrl,
    output logic [DW-1:0]    time_val,
    output logic [DW-1:0]    code_val
);

    logic [DW-1:0] data_q;
    logic [DW-1:0] last_q;
    logic          wr_ctrl;
    logic          wr_time;
    logic          wr_code;
    logic          wr_data;

    assign wr_ctrl = wr && (addr == OFS_CTRL);
    assign wr_time = wr && (addr == OFS_TIME);
    assign wr_code = wr && (addr == OFS_CODE);
    assign wr_data = wr && (addr == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            time_val <= TIME_RST;
            code_val <= '0;
            data_q   <= '0;
            last_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en   <= wdata[6];
                ctrl.unit <= wdata[5:4];
                ctrl.mask <= wdata[EVT_W-1:0];
            end
            if (expire) begin
                ctrl.stat <= 1'b1;
            end else if (wr_ctrl && wdata[7]) begin
                ctrl.stat <= 1'b0;
            end
            if (wr_time) time_val <= wdata;
            if (wr_code) code_val <= wdata;
            if (cap) begin
                data_q <= cap_data;
                last_q <= cap_data;
            end else if (wr_data) begin
                data_q <= wdata;
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CTRL: rdata = ctrl;
            OFS_TIME: rdata = time_val;
            OFS_CODE: rdata = code_val;
            OFS_DATA: rdata = data_q;
            OFS_LAST: rdata = last_q;
            default:  rdata = '0;
        endcase
    end

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[7] && !expire) |=> !ctrl.stat);

    p_last_readonly_r11: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(last_q));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl.stat);

endmodule

// File: rtl/post_wdt_snoop.sv
module post_wdt_snoop #(
    parameter int          AW   = 16,
    parameter int          DW   = 8,
    parameter logic [AW-1:0] BASE = 16'h0080
) (
    input  logic          io_wr,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_data,
    input  logic          pair_en,
    input  logic [DW-1:0] code,
    output logic          cap,
    output logic          match
);

    localparam logic [AW-1:0] PAIR = BASE + AW'(1);

    logic hit;

    assign hit   = (io_addr == BASE) || (pair_en && (io_addr == PAIR));
    assign cap   = io_wr && hit;
    assign match = cap && (io_data == code);

endmodule

// File: rtl/post_wdt_prescale.sv
module post_wdt_prescale #(
    parameter int DIV    = 4,
    parameter int LEVELS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic                        restart,
    input  logic [$clog2(LEVELS)-1:0]   sel,
    output logic                        sel_tick
);

    localparam int              CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0]   TOP = CW'(DIV - 1);

    logic [LEVELS-1:0] stage;

    assign stage[0] = tick;

    generate
        for (genvar k = 1; k < LEVELS; k++) begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    cnt <= '0;
                end else if (stage[k-1]) begin
                    cnt <= (cnt == TOP) ? '0 : cnt + CW'(1);
                end
            end
            assign stage[k] = stage[k-1] && (cnt == TOP);
        end
    endgenerate

    assign sel_tick = stage[sel];

    p_tick_needs_base_r9: assert property (@(posedge clk) disable iff (rst)
        sel_tick |-> tick);

endmodule

// File: rtl/post_wdt_fsm.sv
module post_wdt_fsm
    import post_wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             match,
    input  logic             sel_tick,
    input  logic [CNT_W-1:0] time_val,
    input  logic [EVT_W-1:0] mask,
    output logic             expire,
    output logic             restart,
    output logic [EVT_W-1:0] evt_out
);

    wdt_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             last_unit;

    assign last_unit = (cnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (en) state_nxt = ST_WAIT_CODE;
            end
            ST_WAIT_CODE: begin
                if (match) begin
                    state_nxt = ST_COUNT;
                    cnt_nxt   = time_val;
                end
            end
            ST_COUNT: begin
                if (sel_tick) begin
                    if (last_unit) state_nxt = ST_FIRE;
                    else           cnt_nxt   = cnt - CNT_W'(1);
                end
            end
            ST_FIRE: begin
                if (sel_tick) state_nxt = ST_WAIT_CODE;
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (!en) state_nxt = ST_IDLE;
    end

    always_comb begin
        expire  = en && (state == ST_COUNT) && sel_tick && last_unit;
        restart = en && (state == ST_WAIT_CODE) && match;
        evt_out = (state == ST_FIRE) ? mask : '0;
    end

    p_abort_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_IDLE));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_WAIT_CODE && match) |=>
            (state == ST_COUNT && cnt == $past(time_val)));

    p_no_reload_r12: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_COUNT && !sel_tick) |=> (cnt == $past(cnt)));

    p_fire_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_FIRE && !sel_tick) |=> (state == ST_FIRE));

endmodule

// File: rtl/post_wdt.sv
module post_wdt
    import post_wdt_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] PORT_BASE = 16'h0080,
    parameter int          DIV       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             io_wr,
    input  logic [15:0]      io_addr,
    input  logic [7:0]       io_data,
    input  logic             pair_decode,
    input  logic             base_tick,
    output logic [3:0]       evt_out
);

    localparam int LEVELS = 4;

    wdt_ctrl_t     ctrl;
    logic [DW-1:0] time_val;
    logic [DW-1:0] code_val;
    logic          cap;
    logic          match;
    logic          expire;
    logic          restart;
    logic          sel_tick;

    post_wdt_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cap      (cap),
        .cap_data (io_data),
        .expire   (expire),
        .ctrl     (ctrl),
        .time_val (time_val),
        .code_val (code_val)
    );

    post_wdt_snoop #(
        .AW   (IO_AW),
        .DW   (DW),
        .BASE (PORT_BASE)
    ) u_snoop (
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_data (io_data),
        .pair_en (pair_decode),
        .code    (code_val),
        .cap     (cap),
        .match   (match)
    );

    post_wdt_prescale #(
        .DIV    (DIV),
        .LEVELS (LEVELS)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .tick     (base_tick),
        .restart  (restart),
        .sel      (ctrl.unit),
        .sel_tick (sel_tick)
    );

    post_wdt_fsm #(
        .CNT_W (DW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl.en),
        .match    (match),
        .sel_tick (sel_tick),
        .time_val (time_val),
        .mask     (ctrl.mask),
        .expire   (expire),
        .restart  (restart),
        .evt_out  (evt_out)
    );

    p_status_on_expire_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_out != '0 && $past(evt_out) == '0) |-> ctrl.stat || $past(reg_wr));

endmodule

// File: tb/tb_post_wdt.sv
module tb_post_wdt;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_data = '0;
    logic       pair_decode = 1'b0;
    logic       base_tick = 1'b0;
    logic [3:0] evt_out;

    int checks = 0;
    int errors = 0;
    int ticks_since_arm = 0;
    int evt_seen = 0;
    bit done = 0;

    typedef struct { logic [3:0] mask; int ticks; string tag; } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    post_wdt dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_wr(io_wr),
        .io_addr(io_addr), .io_data(io_data), .pair_decode(pair_decode),
        .base_tick(base_tick), .evt_out(evt_out)
    );

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wreg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic iow(logic [15:0] a, logic [7:0] d, bit arm);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_data = d;
        if (arm) ticks_since_arm = 0;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); base_tick = 1'b1;
            @(negedge clk); base_tick = 1'b0;
        end
    endtask

    task automatic expect_evt(logic [3:0] m, int t, string tag);
        exp_t e;
        e.mask = m; e.ticks = t; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: samples mid high phase, counts ticks and scores events
    initial begin
        logic [3:0] prev = '0;
        forever begin
            @(posedge clk); #5;
            if (base_tick) ticks_since_arm++;
            if (evt_out != '0 && prev == '0) begin
                exp_t e;
                evt_seen++;
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected event got=0x%0h exp=none", evt_out);
                end else begin
                    e = sb_q.pop_front();
                    check({e.tag, " event mask"}, evt_out, e.mask);
                    check({e.tag, " event tick count"}, ticks_since_arm, e.ticks);
                end
            end
            prev = evt_out;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired got=hung exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int seen0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rreg(3'd0, v); check("R1 ctrl", v, 8'h00);
        rreg(3'd1, v); check("R1 time", v, 8'hFF);
        rreg(3'd2, v); check("R1 code", v, 8'h00);
        rreg(3'd3, v); check("R1 data", v, 8'h00);
        rreg(3'd4, v); check("R1 last", v, 8'h00);
        check("R1 evt", evt_out, 0);

        wreg(3'd1, 8'd3);
        wreg(3'd2, 8'hA5);
        wreg(3'd0, 8'h45);

        // R2 non-matching write does not start
        iow(16'h0080, 8'h11, 0);
        ticks(6);
        check("R2 no event", evt_seen, 0);
        rreg(3'd3, v); check("R3 data captured", v, 8'h11);
        rreg(3'd4, v); check("R3 last captured", v, 8'h11);

        // R3 port 0x81 ignored without pair decode
        iow(16'h0081, 8'hA5, 0);
        ticks(5);
        check("R3 pair off no start", evt_seen, 0);
        rreg(3'd3, v); check("R3 pair off no capture", v, 8'h11);

        // R4 / R5 basic countdown
        iow(16'h0080, 8'hA5, 1);
        expect_evt(4'h5, 3, "R4");
        ticks(3);
        check("R5 evt held", evt_out, 4'h5);
        rreg(3'd0, v); check("R4 status set", v, 8'hC5);
        ticks(1);
        check("R5 evt released", evt_out, 0);

        // R6 write-one-to-clear
        wreg(3'd0, 8'h45);
        rreg(3'd0, v); check("R6 write 0 keeps", v, 8'hC5);
        wreg(3'd0, 8'hC5);
        rreg(3'd0, v); check("R6 write 1 clears", v, 8'h45);

        // R12 second match during count ignored
        wreg(3'd1, 8'd4);
        iow(16'h0080, 8'hA5, 1);
        expect_evt(4'h5, 4, "R12");
        ticks(2);
        iow(16'h0080, 8'hA5, 0);
        ticks(2);
        check("R12 evt at original count", evt_out, 4'h5);
        ticks(1);
        wreg(3'd0, 8'hC5);

        // R7 abort by disable
        seen0 = evt_seen;
        iow(16'h0080, 8'hA5, 1);
        ticks(1);
        wreg(3'd0, 8'h05);
        ticks(6);
        check("R7 no event after abort", evt_seen, seen0);
        rreg(3'd0, v); check("R7 status clear", v, 8'h05);
        wreg(3'd0, 8'h45);

        // R8 zero count
        wreg(3'd1, 8'd0);
        iow(16'h0080, 8'hA5, 1);
        expect_evt(4'h5, 1, "R8");
        ticks(1);
        check("R8 evt on first tick", evt_out, 4'h5);
        ticks(1);

        // R9 unit 1 tick rate
        wreg(3'd0, 8'hDA);
        wreg(3'd1, 8'd2);
        iow(16'h0080, 8'hA5, 1);
        expect_evt(4'hA, 8, "R9");
        ticks(8);
        check("R9 evt after 8 base ticks", evt_out, 4'hA);
        ticks(3);
        check("R9 held within slow tick", evt_out, 4'hA);
        ticks(1);
        check("R9 released on slow tick", evt_out, 0);

        // R3 pair decode on
        wreg(3'd0, 8'hC3);
        rreg(3'd0, v); check("R6 clear with new fields", v, 8'h43);
        pair_decode = 1'b1;
        iow(16'h0081, 8'h3C, 0);
        rreg(3'd3, v); check("R3 pair data", v, 8'h3C);
        rreg(3'd4, v); check("R3 pair last", v, 8'h3C);
        wreg(3'd1, 8'd2);
        iow(16'h0081, 8'hA5, 1);
        expect_evt(4'h3, 2, "R3");
        ticks(2);
        ticks(1);
        pair_decode = 1'b0;

        // R11 last register read-only
        wreg(3'd3, 8'h5A);
        rreg(3'd3, v); check("R11 data host write", v, 8'h5A);
        rreg(3'd4, v); check("R11 last unchanged", v, 8'hA5);
        wreg(3'd4, 8'hEE);
        rreg(3'd4, v); check("R11 last write ignored", v, 8'hA5);

        // R10 clear and expiry in the same cycle
        wreg(3'd0, 8'hC3);
        wreg(3'd1, 8'd1);
        iow(16'h0080, 8'hA5, 1);
        expect_evt(4'h3, 1, "R10");
        @(negedge clk);
        base_tick = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'hC3;
        @(negedge clk);
        base_tick = 1'b0;
        reg_wr = 1'b0;
        rreg(3'd0, v); check("R10 set wins", v, 8'hC3);
        ticks(1);

        repeat (4) @(negedge clk);
        check("R5 all expected events seen", sb_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule